// File: doc/BRIEF.md
# Watchdog Configuration Register Slave on a Two-Wire Serial Bus

This block is a two-wire serial-bus slave (I2C-style framing, start and stop conditions, ninth-clock acknowledge) that owns one 8-bit configuration byte. The byte holds a two-bit watchdog period selector, which stands for nonvolatile storage, and two volatile unlock latches. The block runs from a fast system clock. It oversamples the bus lines through synchronizers and pulls the data line low when it acknowledges or sends a zero.

Writes follow a fixed frame: device address, register address and exactly one data byte. A write takes effect only at a clean stop that follows the acknowledged data byte. Changing the period selector needs three separate write frames: first the primary latch, then the secondary latch, then the new value. A stored period change starts a busy interval, which models the nonvolatile programming time. During that interval the block ignores the bus. A write-protect input blocks every change. Reads use a dummy write of the register address, a repeated start and a read address. They return one byte, MSB first.

Register byte layout: bit 6 and bit 5 are the period selector (bit 6 is the high bit), bit 2 is the secondary latch, bit 1 is the primary latch, and bits 7, 4, 3 and 0 read as zero. The selector code 11 means the watchdog is off and is the reset value. Codes 00, 01 and 10 select the long, medium and short periods.

Top module: `wdr_ctrl_slave`

## Requirements
- R1: After reset the data line is released, `wd_sel_o` is 11, both latches are clear, and a read returns 60h.
- R2: The device address byte is 1011 in bits 7..4, 000 in bits 3..1 and the read flag in bit 0 (so B0h writes and B1h reads). Any other address byte gets no acknowledge, and every following byte is ignored until the next start.
- R3: After a write address, the register address byte FFh is acknowledged. Any other value gets no acknowledge and ends the frame without effect.
- R4: While the primary latch is clear, the only data byte accepted is 02h. Any other byte gets no acknowledge and leaves the register unchanged.
- R5: With the primary latch set and the secondary latch clear, 02h keeps the state, 06h sets the secondary latch, and 00h clears the primary latch. None of these starts a busy interval, and the secondary latch is never set while the primary latch is clear.
- R6: With the secondary latch set, a byte of the form 0xy0_0010 stores xy into the selector and clears the secondary latch. A byte of the form 0xy0_0110 is acknowledged but leaves the selector unchanged and the secondary latch set. The selector changes only at a stop.
- R7: While `wp_i` is high when a data byte completes, that byte gets no acknowledge and the register does not change.
- R8: A second data byte in one write frame gets no acknowledge and discards the whole write.
- R9: A stop that arrives before the data byte and its acknowledge are complete discards the write.
- R10: A stop that commits a selector write starts a busy interval of `BUSY_CYCLES` clocks. During that interval starts are ignored and nothing is acknowledged.
- R11: A read address after the dummy write is acknowledged. The slave then shifts out the register byte MSB first and releases the line after that one byte.
- R12: A repeated start after an acknowledged data byte, given instead of a stop, discards the pending write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| wp_i | input | 1 | Write protect; high blocks all register changes |
| sda_low_o | output | 1 | High pulls the data line low (open-drain enable) |
| wd_sel_o | output | 2 | Current watchdog period selector |

## Verification
The hardest state to reach is the secondary latch set together with a pending selector write. The bus must first complete two clean unlock frames. A third frame then carries the value, and the bench has to choose how that frame ends: with a stop, with a repeated start, with an extra byte, or with write protect raised. The bench brings each latch up with real write frames and confirms every step with a full dummy-write-plus-read frame. It then ends the value frame in each of those ways and reads back through the bus to see whether the selector moved. Right after the committing stop, it opens a new frame at once to catch the busy interval.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_REG, ST_REG_ACK,
        ST_DATA, ST_DATA_ACK, ST_EXTRA, ST_RD, ST_SKIP
    } state_e;

    typedef struct packed {
        logic [1:0] wd;
        logic       rwel;
        logic       wel;
    } regs_t;

    typedef struct packed {
        logic  accept;
        logic  nv;
        regs_t nxt;
    } decode_t;

    function automatic logic [7:0] pack_reg(input regs_t r);
        return {1'b0, r.wd, 2'b00, r.rwel, r.wel, 1'b0};
    endfunction

    // Outcome of a completed data byte, given current latches and protect.
    function automatic decode_t decode_write(input logic [7:0] b, input regs_t cur,
                                             input logic wp);
        decode_t r;
        r.accept = 1'b0;
        r.nv     = 1'b0;
        r.nxt    = cur;
        if (!wp && !b[7] && (b[4:3] == 2'b00) && !b[0]) begin
            if (!cur.wel) begin
                if (b == 8'h02) begin
                    r.accept  = 1'b1;
                    r.nxt.wel = 1'b1;
                end
            end else if (cur.rwel) begin
                if (b[2:1] == 2'b01) begin
                    r.accept   = 1'b1;
                    r.nv       = 1'b1;
                    r.nxt.wd   = b[6:5];
                    r.nxt.rwel = 1'b0;
                end else if (b[2:1] == 2'b11) begin
                    r.accept = 1'b1;
                end
            end else if (b[6:5] == 2'b00) begin
                case (b[2:1])
                    2'b01: r.accept = 1'b1;
                    2'b11: begin r.accept = 1'b1; r.nxt.rwel = 1'b1; end
                    2'b00: begin r.accept = 1'b1; r.nxt.wel = 1'b0; end
                    default: r.accept = 1'b0;
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/wdr_line_sampler.sv
module wdr_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] scl_sync_q, sda_sync_q;
    logic          scl_prev_q, sda_prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync_q <= '1;
                    sda_sync_q <= '1;
                end else begin
                    scl_sync_q <= scl_i;
                    sda_sync_q <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync_q <= '1;
                    sda_sync_q <= '1;
                end else begin
                    scl_sync_q <= {scl_sync_q[LAST-1:0], scl_i};
                    sda_sync_q <= {sda_sync_q[LAST-1:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_o;
            sda_prev_q <= sda_o;
        end
    end

    assign scl_o      = scl_sync_q[LAST];
    assign sda_o      = sda_sync_q[LAST];
    assign scl_rise_o = scl_o & ~scl_prev_q;
    assign scl_fall_o = ~scl_o & scl_prev_q;
    assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
    assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;

endmodule

// File: rtl/wdr_busy_timer.sv
module wdr_busy_timer #(
    parameter int unsigned CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int W = $clog2(CYCLES + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load_i)          cnt_q <= W'(CYCLES);
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/wdr_ctrl_slave.sv
module wdr_ctrl_slave
    import wdr_pkg::*;
#(
    parameter logic [3:0]  DEV_TYPE    = 4'b1011,
    parameter logic [7:0]  REG_ADDR    = 8'hFF,
    parameter logic [1:0]  WD_RESET    = 2'b11,
    parameter int unsigned BUSY_CYCLES = 2_000_000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       wp_i,
    output logic       sda_low_o,
    output logic [1:0] wd_sel_o
);
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        state_e            st;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              full;
        logic              rw;
        logic              drive;
        regs_t             cfg;
        regs_t             pend;
        logic              pend_nv;
        logic              pend_ok;
    } fsm_t;

    fsm_t q, d;
    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic busy, load_busy;
    logic wel_q, rwel_q, in_idle;

    wdr_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_evt), .stop_o(stop_evt)
    );

    wdr_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .load_i(load_busy), .busy_o(busy)
    );

    always_comb begin
        decode_t           dec;
        logic [BYTE_W-1:0] rd_byte;
        d         = q;
        load_busy = 1'b0;
        dec       = decode_write(q.sh, q.cfg, wp_i);
        rd_byte   = pack_reg(q.cfg);
        if (busy) begin
            d.st    = ST_IDLE;
            d.drive = 1'b0;
        end else if (start_evt) begin
            d.st      = ST_ADDR;
            d.cnt     = '0;
            d.full    = 1'b0;
            d.drive   = 1'b0;
            d.pend_ok = 1'b0;
        end else if (stop_evt) begin
            if (q.st == ST_EXTRA && q.pend_ok) begin
                d.cfg     = q.pend;
                load_busy = q.pend_nv;
            end
            d.st      = ST_IDLE;
            d.drive   = 1'b0;
            d.pend_ok = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_REG, ST_DATA: begin
                    if (scl_rise) begin
                        d.sh   = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt  = q.cnt + 1'b1;
                        d.full = (q.cnt == LAST_BIT);
                    end else if (scl_fall && q.full) begin
                        d.full = 1'b0;
                        d.cnt  = '0;
                        if (q.st == ST_ADDR) begin
                            d.rw    = q.sh[0];
                            d.drive = (q.sh[7:1] == {DEV_TYPE, 3'b000});
                            d.st    = d.drive ? ST_ADDR_ACK : ST_SKIP;
                        end else if (q.st == ST_REG) begin
                            d.drive = (q.sh == REG_ADDR);
                            d.st    = d.drive ? ST_REG_ACK : ST_SKIP;
                        end else begin
                            d.pend    = dec.nxt;
                            d.pend_nv = dec.nv;
                            d.pend_ok = dec.accept;
                            d.drive   = dec.accept;
                            d.st      = dec.accept ? ST_DATA_ACK : ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (q.rw) begin
                            d.st    = ST_RD;
                            d.sh    = rd_byte;
                            d.drive = ~rd_byte[BYTE_W-1];
                            d.cnt   = '0;
                        end else begin
                            d.st    = ST_REG;
                            d.drive = 1'b0;
                        end
                    end
                end
                ST_REG_ACK: if (scl_fall) begin d.st = ST_DATA;  d.drive = 1'b0; end
                ST_DATA_ACK: if (scl_fall) begin d.st = ST_EXTRA; d.drive = 1'b0; d.full = 1'b0; end
                ST_EXTRA: begin
                    // A clock pulse completed here is the first bit of an extra byte.
                    if (scl_rise) d.full = 1'b1;
                    else if (scl_fall && q.full) begin
                        d.st      = ST_SKIP;
                        d.pend_ok = 1'b0;
                        d.full    = 1'b0;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.drive = 1'b0;
                            d.st    = ST_SKIP;
                        end else begin
                            d.sh    = {q.sh[BYTE_W-2:0], 1'b0};
                            d.drive = ~q.sh[BYTE_W-2];
                            d.cnt   = q.cnt + 1'b1;
                        end
                    end
                end
                default: d.drive = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.cfg.wd <= WD_RESET;
        end else begin
            q <= d;
        end
    end

    assign sda_low_o = q.drive;
    assign wd_sel_o  = q.cfg.wd;
    assign wel_q     = q.cfg.wel;
    assign rwel_q    = q.cfg.rwel;
    assign in_idle   = (q.st == ST_IDLE);

endmodule

// File: rtl/wdr_ctrl_sva.sv
module wdr_ctrl_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_evt,
    input logic       busy,
    input logic       in_idle,
    input logic       wel,
    input logic       rwel,
    input logic       sda_low_o,
    input logic [1:0] wd_sel_o
);
    // R1: an idle slave never holds the data line
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> !sda_low_o);

    // R10: nothing is driven during the programming interval
    assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_low_o);

    // R10: the busy interval begins only right after a stop
    assert_busy_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));

    // R6: the selector moves only on the cycle after a stop
    assert_wd_only_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wd_sel_o) |-> $past(stop_evt));

    // R6: a selector change leaves the secondary latch clear
    assert_wd_change_clears_rwel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wd_sel_o) |-> !rwel);

    // R5: secondary latch implies primary latch
    assert_rwel_needs_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rwel |-> wel);

endmodule

bind wdr_ctrl_slave wdr_ctrl_sva u_sva (
    .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt), .busy(busy), .in_idle(in_idle),
    .wel(wel_q), .rwel(rwel_q), .sda_low_o(sda_low_o), .wd_sel_o(wd_sel_o)
);

// File: tb/wdr_ctrl_slave_tb.sv
module wdr_ctrl_slave_tb;
    localparam int T    = 8;
    localparam int BUSY = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic       sda_low;
    logic [1:0] wd_sel;
    wire        sda_line = sda_m & ~sda_low;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    int    exp_q[$];
    int    obs_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    wdr_ctrl_slave #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .wp_i(wp),
        .sda_low_o(sda_low), .wd_sel_o(wd_sel)
    );

    // Monitor: pops expected items and compares with observed results.
    initial forever begin
        @(posedge clk);
        while (obs_q.size() > 0 && exp_q.size() > 0) begin
            int    e, o;
            string t;
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (e != o) begin
                n_fail++;
                $display("FAIL %s: actual %0h expected %0h", t, o, e);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input int exp, input int obs, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        obs_q.push_back(obs);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(T);
        scl_m = 1'b1; tick(T);
        sda_m = 1'b0; tick(T);
        scl_m = 1'b0; tick(T);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(T);
        scl_m = 1'b1; tick(T);
        sda_m = 1'b1; tick(2 * T);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(T);
            scl_m = 1'b1; tick(2 * T);
            scl_m = 1'b0; tick(T);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int exp_ack, input string tag);
        exp_q.push_back(exp_ack);
        tag_q.push_back(tag);
        send_bits(b, 8);
        sda_m = 1'b1; tick(T);
        scl_m = 1'b1; tick(T);
        obs_q.push_back(sda_line ? 0 : 1);
        tick(T);
        scl_m = 1'b0; tick(T);
    endtask

    task automatic recv_byte(input int exp, input string tag);
        logic [7:0] v = '0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(T);
            scl_m = 1'b1; tick(T);
            v = {v[6:0], sda_line};
            tick(T);
            scl_m = 1'b0; tick(T);
        end
        tick(T);
        scl_m = 1'b1; tick(2 * T);
        scl_m = 1'b0; tick(T);
        obs_q.push_back(int'(v));
    endtask

    task automatic rd_reg(input int exp, input string tag);
        bus_start();
        send_byte(8'hB0, 1, {tag, " dummy write addr"});
        send_byte(8'hFF, 1, {tag, " reg addr"});
        bus_start();
        send_byte(8'hB1, 1, {tag, " R11 read addr ack"});
        recv_byte(exp, {tag, " read data"});
        bus_stop();
    endtask

    task automatic wr_reg(input logic [7:0] v, input int exp_ack, input string tag);
        bus_start();
        send_byte(8'hB0, 1, {tag, " addr"});
        send_byte(8'hFF, 1, {tag, " reg addr"});
        send_byte(v, exp_ack, {tag, " data ack"});
        bus_stop();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(4);
        expect_now(0, int'(sda_low), "R1 data line released");
        expect_now(3, int'(wd_sel), "R1 selector reset 11");
        rd_reg(8'h60, "R1 reset read");

        // R2: wrong device address, then ignored byte
        bus_start();
        send_byte(8'hA0, 0, "R2 mismatched address nack");
        send_byte(8'hFF, 0, "R2 ignored after mismatch");
        bus_stop();
        bus_start();
        send_byte(8'hB2, 0, "R2 nonzero bits 3..1 nack");
        bus_stop();

        // R3: wrong register address
        bus_start();
        send_byte(8'hB0, 1, "R3 addr");
        send_byte(8'h01, 0, "R3 bad register address nack");
        bus_stop();

        // R4: latch clear rejects anything but 02h
        wr_reg(8'h06, 0, "R4 06h with latch clear");
        wr_reg(8'h42, 0, "R4 42h with latch clear");
        rd_reg(8'h60, "R4 unchanged");

        // R5: primary then secondary latch
        wr_reg(8'h02, 1, "R5 set primary");
        rd_reg(8'h62, "R5 primary set");
        wr_reg(8'h06, 1, "R5 set secondary");
        rd_reg(8'h66, "R5 both set");
        expect_now(3, int'(wd_sel), "R5 selector untouched");

        // R7: write protect
        wp = 1'b1;
        wr_reg(8'h02, 0, "R7 protected data nack");
        wp = 1'b0;
        rd_reg(8'h66, "R7 unchanged");

        // R8: second data byte aborts
        bus_start();
        send_byte(8'hB0, 1, "R8 addr");
        send_byte(8'hFF, 1, "R8 reg addr");
        send_byte(8'h02, 1, "R8 first data ack");
        send_byte(8'h02, 0, "R8 second data nack");
        bus_stop();
        rd_reg(8'h66, "R8 write discarded");

        // R9: stop in the middle of the data byte
        bus_start();
        send_byte(8'hB0, 1, "R9 addr");
        send_byte(8'hFF, 1, "R9 reg addr");
        send_bits(8'h02, 4);
        bus_stop();
        rd_reg(8'h66, "R9 write discarded");

        // R12: repeated start instead of stop
        bus_start();
        send_byte(8'hB0, 1, "R12 addr");
        send_byte(8'hFF, 1, "R12 reg addr");
        send_byte(8'h02, 1, "R12 data ack");
        bus_start();
        send_byte(8'hB1, 1, "R12 read addr");
        recv_byte(8'h66, "R12 pending write dropped");
        bus_stop();

        // R6 + R10: commit 00 selector, busy interval
        wr_reg(8'h02, 1, "R6 store 00");
        expect_now(0, int'(wd_sel), "R6 selector now 00");
        bus_start();
        send_byte(8'hB0, 0, "R10 busy nack");
        bus_stop();
        tick(BUSY);
        rd_reg(8'h02, "R6 secondary cleared after store");

        // R6: 02h,06h,46h keeps selector, secondary stays set
        wr_reg(8'h06, 1, "R6 rearm secondary");
        wr_reg(8'h46, 1, "R6 keep form ack");
        rd_reg(8'h06, "R6 keep form no change");
        expect_now(0, int'(wd_sel), "R6 selector still 00");
        wr_reg(8'h42, 1, "R6 store 10");
        tick(BUSY);
        expect_now(2, int'(wd_sel), "R6 selector now 10");
        rd_reg(8'h42, "R6 readback 42h");

        // R5: 00h clears primary latch
        wr_reg(8'h00, 1, "R5 clear primary");
        rd_reg(8'h40, "R5 primary cleared");

        tick(10);
        if (!done) begin
            done = 1'b1;
            report();
            $finish;
        end
    end

endmodule